// File: doc/BRIEF.md
# Four-Level Page Table Walker with Walk Cache

This block resolves a translation miss by reading a four-level radix page table held in memory. A 48-bit virtual address supplies four 9-bit table indices, one per level. A root table base starts the walk. Each level costs one 64-bit read over a simple request/response port. The walk stops on a leaf entry and returns the physical address and its page size, or it stops on a non-present entry with a fault. A leaf can be a 1GB page at level 2, a 2MB page at level 3, or a 4KB page at level 4.

A small walk cache holds the pointer entries read at the upper three levels. Each one is tagged by the virtual-address prefix that selected it. A later miss that shares a cached prefix starts at the level below the deepest matching entry. It therefore needs fewer memory reads. A flush input empties the cache. The block services one walk at a time and holds off new requests until the current walk has returned.

Top module: `ptw_top`

## Requirements
- R1: After reset, req_ready_o is 1 and done_o and mem_req_o are 0.
- R2: The level-n index (n = 1..4) is VA[47-9(n-1) : 39-9(n-1)]. Each read address is the current table base (PPN shifted left by 12) plus index times 8. A walk from the root reads level 1 first, and each level costs exactly one read.
- R3: An entry with bit 0 (present) clear stops the walk at any level. The result is fault_o=1, size_o=0 and pa_o=0.
- R4: A present entry at level 2 with bit 7 set is a leaf. It gives size_o=2 (1GB), with pa_o = entry[PA_W-1:30] joined to VA[29:0].
- R5: A present entry at level 3 with bit 7 set is a leaf. It gives size_o=1 (2MB), with pa_o = entry[PA_W-1:21] joined to VA[20:0].
- R6: A present entry at level 4 is always a leaf. It gives size_o=0 (4KB), with pa_o = entry[PA_W-1:12] joined to VA[11:0]. Bit 7 has no effect at level 1, where the entry is always a pointer.
- R7: A present non-leaf entry read at level n (1..3) is cached under VA[47 : 48-9n]. A later walk starts at level k+1 when k is the deepest level whose prefix is cached. It then reads 4-k levels when it ends at level 4.
- R8: A one-cycle flush_i pulse empties the walk cache. The next walk then starts again at the root.
- R9: Only one walk is in flight. req_ready_o stays 0 from the accepting edge until done_o. done_o is a one-cycle pulse in the cycle after the last response.
- R10: Entry bits 63:PA_W and flag bits other than 0 and 7 do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empties the walk cache |
| root_ppn_i | input | PA_W-12 | Root table page number |
| req_valid_i | input | 1 | Miss request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 48 | Virtual address to translate |
| mem_req_o | output | 1 | One-cycle table read request |
| mem_addr_o | output | PA_W | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_o | output | 1 | Walk hit a non-present entry |
| size_o | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |
| pa_o | output | PA_W | Translated physical address |

## Verification
The assertions assume several things about the inputs. A read response arrives only while a read is outstanding, and at least one cycle after its request. A request is offered only while req_ready_o is high. Table contents stay fixed between flushes, so cached pointers agree with memory. The bench keeps to these assumptions in four ways. Its memory is a fixed function of the address, with latency from 1 to 3 cycles. It answers each request once. It keeps the root constant. It issues a new request only after done_o has been seen.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W  = 48;
  localparam int unsigned LVLS  = 4;
  localparam int unsigned IDX_W = 9;
  localparam int unsigned PG_W  = 12;
  localparam int unsigned PTE_W = 64;
  localparam int unsigned TAG_W = VA_W - PG_W - IDX_W;

  typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_2M = 2'd1, SZ_1G = 2'd2} pg_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} wst_e;

  function automatic logic [IDX_W-1:0] lvl_index(input logic [VA_W-1:0] va,
                                                 input logic [1:0] lvl);
    logic [VA_W-1:0] sh;
    sh = va >> (PG_W + IDX_W * (LVLS - 1 - int'(lvl)));
    return sh[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/ptw_pwc.sv
module ptw_pwc
  import ptw_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned PPN_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic [1:0]       start_lvl_o,
  output logic [PPN_W-1:0] start_ppn_o,
  input  logic             fill_i,
  input  logic [1:0]       fill_lvl_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PPN_W-1:0] fill_ppn_i
);
  localparam int unsigned NLV   = LVLS - 1;
  localparam int unsigned PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [NLV-1:0] hit_any;
  logic [PPN_W-1:0] hit_ppn [NLV];

  for (genvar g = 0; g < NLV; g++) begin : g_lvl
    localparam logic [TAG_W-1:0] MASK = {TAG_W{1'b1}} << (TAG_W - IDX_W * (g + 1));
    logic [N_ENT-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [N_ENT];
    logic [PPN_W-1:0] ppn_q [N_ENT];
    logic [PTR_W-1:0] ptr_q;
    logic [N_ENT-1:0] hit_g;
    logic [PPN_W-1:0] hppn_g;
    logic [TAG_W-1:0] lk_m, fl_m;

    assign lk_m = lk_tag_i & MASK;
    assign fl_m = fill_tag_i & MASK;

    always_comb begin
      hit_g  = '0;
      hppn_g = '0;
      for (int e = 0; e < N_ENT; e++) begin
        if (vld_q[e] && tag_q[e] == lk_m) begin
          hit_g[e] = 1'b1;
          hppn_g   = hppn_g | ppn_q[e];
        end
      end
    end

    assign hit_any[g] = |hit_g;
    assign hit_ppn[g] = hppn_g;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
        ptr_q <= '0;
      end else if (flush_i) begin
        vld_q <= '0;
      end else if (fill_i && fill_lvl_i == 2'(g)) begin
        vld_q[ptr_q] <= 1'b1;
        tag_q[ptr_q] <= fl_m;
        ppn_q[ptr_q] <= fill_ppn_i;
        ptr_q        <= (ptr_q == PTR_W'(N_ENT - 1)) ? '0 : ptr_q + 1'b1;
      end
    end

    // a prefix is filled only after missing at its level
    p_one_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit_g));
    p_flush_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (vld_q == '0));
  end

  // deepest matching level wins
  always_comb begin
    start_lvl_o = 2'd0;
    start_ppn_o = root_ppn_i;
    for (int g = 0; g < NLV; g++) begin
      if (hit_any[g]) begin
        start_lvl_o = 2'(g + 1);
        start_ppn_o = hit_ppn[g];
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [VA_W-1:0]      req_va_i,
  input  logic [1:0]           start_lvl_i,
  input  logic [PA_W-PG_W-1:0] start_ppn_i,
  output logic                 mem_req_o,
  output logic [PA_W-1:0]      mem_addr_o,
  input  logic                 mem_rsp_valid_i,
  input  logic [PTE_W-1:0]     mem_rsp_data_i,
  output logic                 fill_o,
  output logic [1:0]           fill_lvl_o,
  output logic [TAG_W-1:0]     fill_tag_o,
  output logic [PA_W-PG_W-1:0] fill_ppn_o,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [1:0]           size_o,
  output logic [PA_W-1:0]      pa_o
);
  localparam int unsigned PPN_W = PA_W - PG_W;

  wst_e                 st_q;
  logic [1:0]           lvl_q;
  logic [PPN_W-1:0]     ppn_q;
  logic [VA_W-1:0]      va_q;
  logic                 done_q, fault_q;
  pg_size_e             size_q;
  logic [PA_W-1:0]      pa_q;

  logic [PPN_W-1:0]     e_ppn;
  logic                 present, is_leaf;
  pg_size_e             leaf_sz;
  logic [PA_W-1:0]      leaf_pa;
  logic                 unused_pte;

  assign unused_pte = ^{mem_rsp_data_i[PTE_W-1:PA_W], mem_rsp_data_i[11:8],
                        mem_rsp_data_i[6:1]};

  assign e_ppn   = mem_rsp_data_i[PA_W-1:PG_W];
  assign present = mem_rsp_data_i[0];
  assign is_leaf = (lvl_q == 2'd3) ||
                   (((lvl_q == 2'd1) || (lvl_q == 2'd2)) && mem_rsp_data_i[7]);

  always_comb begin
    case (lvl_q)
      2'd1:    begin leaf_sz = SZ_1G; leaf_pa = {e_ppn[PPN_W-1:18], va_q[29:0]}; end
      2'd2:    begin leaf_sz = SZ_2M; leaf_pa = {e_ppn[PPN_W-1:9], va_q[20:0]}; end
      default: begin leaf_sz = SZ_4K; leaf_pa = {e_ppn, va_q[11:0]}; end
    endcase
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_ISSUE);
  assign mem_addr_o  = {ppn_q, lvl_index(va_q, lvl_q), 3'b000};

  assign fill_o     = (st_q == ST_WAIT) && mem_rsp_valid_i && present && !is_leaf;
  assign fill_lvl_o = lvl_q;
  assign fill_tag_o = va_q[VA_W-1 -: TAG_W];
  assign fill_ppn_o = e_ppn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      ppn_q   <= '0;
      va_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      size_q  <= SZ_4K;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q  <= req_va_i;
          lvl_q <= start_lvl_i;
          ppn_q <= start_ppn_i;
          st_q  <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!present) begin
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            size_q  <= SZ_4K;
            pa_q    <= '0;
            st_q    <= ST_IDLE;
          end else if (is_leaf) begin
            done_q  <= 1'b1;
            fault_q <= 1'b0;
            size_q  <= leaf_sz;
            pa_q    <= leaf_pa;
            st_q    <= ST_IDLE;
          end else begin
            lvl_q <= lvl_q + 2'd1;
            ppn_q <= e_ppn;
            st_q  <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign size_o  = size_q;
  assign pa_o    = pa_q;

  // input contract: responses only for an outstanding read
  p_rsp_in_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> (st_q == ST_WAIT));
  p_req_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_done_after_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rsp_valid_i));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fault_np_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> !$past(mem_rsp_data_i[0]));
  p_lvl_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ISSUE && $past(st_q) == ST_WAIT) |-> (lvl_q == $past(lvl_q) + 2'd1));
  p_1g_lvl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && size_o == SZ_1G) |-> ($past(lvl_q) == 2'd1));
  p_2m_lvl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && size_o == SZ_2M) |-> ($past(lvl_q) == 2'd2));
  p_4k_lvl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && size_o == SZ_4K) |-> ($past(lvl_q) == 2'd3));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W    = 52,
  parameter int unsigned PWC_ENT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic [PA_W-13:0]     root_ppn_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [47:0]          req_va_i,
  output logic                 mem_req_o,
  output logic [PA_W-1:0]      mem_addr_o,
  input  logic                 mem_rsp_valid_i,
  input  logic [63:0]          mem_rsp_data_i,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [1:0]           size_o,
  output logic [PA_W-1:0]      pa_o
);
  localparam int unsigned PPN_W = PA_W - PG_W;

  logic [1:0]       start_lvl;
  logic [PPN_W-1:0] start_ppn;
  logic             fill;
  logic [1:0]       fill_lvl;
  logic [TAG_W-1:0] fill_tag;
  logic [PPN_W-1:0] fill_ppn;

  ptw_pwc #(.N_ENT(PWC_ENT), .PPN_W(PPN_W)) u_pwc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .lk_tag_i    (req_va_i[VA_W-1 -: TAG_W]),
    .root_ppn_i  (root_ppn_i),
    .start_lvl_o (start_lvl),
    .start_ppn_o (start_ppn),
    .fill_i      (fill),
    .fill_lvl_i  (fill_lvl),
    .fill_tag_i  (fill_tag),
    .fill_ppn_i  (fill_ppn)
  );

  ptw_walker #(.PA_W(PA_W)) u_walk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_va_i        (req_va_i),
    .start_lvl_i     (start_lvl),
    .start_ppn_i     (start_ppn),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .fill_o          (fill),
    .fill_lvl_o      (fill_lvl),
    .fill_tag_o      (fill_tag),
    .fill_ppn_o      (fill_ppn),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .size_o          (size_o),
    .pa_o            (pa_o)
  );
endmodule

// File: tb/ptw_top_tb.sv
`timescale 1ns/1ps
module ptw_top_tb;
  localparam int PA_W = 52;
  localparam longint unsigned PA_MASK = (64'h1 << PA_W) - 1;
  localparam longint unsigned ROOT = 64'h0ABCD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [47:0] req_va = '0;
  logic rsp_v = 1'b0;
  logic [63:0] rsp_d = '0;
  logic req_ready, mem_req, done, fault;
  logic [PA_W-1:0] mem_addr, pa;
  logic [1:0] size;

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0;
  int lat = 1;
  longint unsigned first_addr;
  longint unsigned cyc = 0;

  always #2.5 clk = ~clk;

  ptw_top #(.PA_W(PA_W), .PWC_ENT(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .root_ppn_i(ROOT[PA_W-13:0]),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rsp_valid_i(rsp_v),
    .mem_rsp_data_i(rsp_d), .done_o(done), .fault_o(fault), .size_o(size), .pa_o(pa)
  );

  // table content: kind from index[1:0] = address bits 4:3
  function automatic longint unsigned ent(longint unsigned a);
    longint unsigned p, e;
    p = ((a * 64'h9E3779B97F4A7C15) >> 17) & ((64'h1 << (PA_W - 12)) - 1);
    e = p << 12;
    case (a[4:3])
      2'd0: e = e | 64'h1;
      2'd1: e = e | 64'h81;
      2'd2: e = e | 64'h67 | 64'hFFF0_0000_0000_0000;
      default: e = e | 64'h80;
    endcase
    return e;
  endfunction

  task automatic model(input logic [47:0] va, output bit f, output int sz,
                       output longint unsigned pexp, output int nlv);
    longint unsigned base, e, m;
    base = ROOT << 12;
    f = 0; sz = 0; pexp = 0; nlv = 0;
    for (int l = 0; l < 4; l++) begin
      longint unsigned idx;
      idx = (longint'(va) >> (12 + 9 * (3 - l))) & 64'h1FF;
      e = ent(base + idx * 8);
      nlv++;
      if (e[0] == 1'b0) begin f = 1; return; end
      if (l == 3 || ((l == 1 || l == 2) && e[7])) begin
        sz = (l == 1) ? 2 : (l == 2) ? 1 : 0;
        m  = (l == 1) ? 64'h3FFF_FFFF : (l == 2) ? 64'h1F_FFFF : 64'hFFF;
        pexp = ((e & PA_MASK) & ~m) | (longint'(va) & m);
        return;
      end
      base = (e & PA_MASK) & ~64'hFFF;
    end
  endtask

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory: answers each read once after lat cycles
  initial begin
    @(negedge clk);
    forever begin
      if (mem_req) begin
        longint unsigned a;
        a = longint'(mem_addr);
        rd_cnt++;
        if (rd_cnt == 1) first_addr = a;
        repeat (lat) @(negedge clk);
        rsp_d = ent(a);
        rsp_v = 1'b1;
        @(negedge clk);
        rsp_v = 1'b0;
      end else @(negedge clk);
    end
  end

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
  endtask

  task automatic walk(input logic [47:0] va, input int l, output int nrd);
    bit f, busy_ok;
    int sz, nlv, t;
    longint unsigned pexp;
    lat = l;
    rd_cnt = 0;
    busy_ok = 1;
    check(req_ready === 1'b1, "R9 ready before request", longint'(req_ready), 1);
    req_valid = 1'b1;
    req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (done !== 1'b1 && t < 300) begin
      if (req_ready !== 1'b0) busy_ok = 0;
      @(negedge clk);
      t++;
    end
    nrd = rd_cnt;
    check(t < 300 && busy_ok, "R9 busy/no-timeout", longint'(t), 0);
    model(va, f, sz, pexp, nlv);
    if (f) begin
      check(fault === 1'b1 && size === 2'd0 && pa === '0, "R3 fault result",
            {fault, size, 48'(pa)}, {1'b1, 2'd0, 48'd0});
    end else begin
      string tg;
      tg = (sz == 2) ? "R4 1GB" : (sz == 1) ? "R5 2MB" : "R6 4KB";
      check(fault === 1'b0 && int'(size) == sz, {tg, " size"}, longint'(size), sz);
      check(longint'(pa) == pexp, {tg, " pa"}, longint'(pa), pexp);
    end
    check(nrd <= nlv, "R7 reads not above root walk", nrd, nlv);
  endtask

  function automatic logic [47:0] mk(input logic [8:0] a, input logic [8:0] b,
                                     input logic [8:0] c, input logic [8:0] d,
                                     input logic [11:0] off);
    return {a, b, c, d, off};
  endfunction

  initial begin
    if (cyc > 190000) $display("FAIL watchdog cyc=%0d", cyc);
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nrd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready === 1'b1, "R1 ready", longint'(req_ready), 1);
    check(done === 1'b0, "R1 done", longint'(done), 0);
    check(mem_req === 1'b0, "R1 mem_req", longint'(mem_req), 0);

    // R2 / R7 / R8 directed
    do_flush();
    walk(mk(9'h010, 9'h024, 9'h048, 9'h0C4, 12'h123), 1, nrd);
    check(nrd == 4, "R2 root walk reads", nrd, 4);
    check(first_addr == (ROOT << 12) + 64'h010 * 8, "R2 first address", first_addr,
          (ROOT << 12) + 64'h80);
    walk(mk(9'h010, 9'h024, 9'h048, 9'h0C4, 12'hABC), 2, nrd);
    check(nrd == 1, "R7 level3 prefix hit", nrd, 1);
    walk(mk(9'h010, 9'h024, 9'h04C, 9'h0C4, 12'h001), 3, nrd);
    check(nrd == 2, "R7 level2 prefix hit", nrd, 2);
    walk(mk(9'h010, 9'h028, 9'h048, 9'h0C4, 12'h002), 1, nrd);
    check(nrd == 3, "R7 level1 prefix hit", nrd, 3);
    do_flush();
    walk(mk(9'h010, 9'h024, 9'h048, 9'h0C4, 12'h123), 2, nrd);
    check(nrd == 4, "R8 flush forces root walk", nrd, 4);

    // R3 faults
    walk(mk(9'h013, 9'h000, 9'h000, 9'h000, 12'h0), 1, nrd);
    check(nrd == 1 && fault === 1'b1, "R3 level1 fault", nrd, 1);
    walk(mk(9'h010, 9'h024, 9'h048, 9'h0C7, 12'h0), 1, nrd);
    check(fault === 1'b1, "R3 level4 fault", longint'(fault), 1);
    // R4 / R5 / R6 leaves
    walk(mk(9'h010, 9'h025, 9'h1FF, 9'h155, 12'hFFF), 2, nrd);
    check(size === 2'd2, "R4 level2 leaf", longint'(size), 2);
    walk(mk(9'h010, 9'h024, 9'h049, 9'h0AA, 12'h777), 3, nrd);
    check(size === 2'd1, "R5 level3 leaf", longint'(size), 1);
    walk(mk(9'h011, 9'h024, 9'h048, 9'h0C5, 12'h555), 1, nrd);
    check(size === 2'd0 && fault === 1'b0, "R6 bit7 ignored at levels 1 and 4",
          longint'(size), 0);
    // R10 extra bits
    walk(mk(9'h012, 9'h026, 9'h04A, 9'h0C6, 12'h3C3), 2, nrd);
    check(size === 2'd0 && fault === 1'b0 && nrd == 4, "R10 extra bits ignored",
          longint'(nrd), 4);

    // exhaustive kind sweep over four levels
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            walk(mk(9'(64 + a), 9'(128 + b), 9'(192 + c), 9'(256 + d),
                    12'(a * 1000 + d * 7)), 1 + ((a + b + c + d) % 3), nrd);
    // scattered addresses
    for (int n = 0; n < 96; n++)
      walk(48'(longint'(n) * 64'h5DEECE66D + 64'hB), 1 + (n % 3), nrd);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule